// File: doc/BRIEF.md
# Link Bring-Up Sequencer

This block is a receive-side state machine that takes a serial link from reset to carrying user data. It observes the lock indication of the clock-recovery loop and the type of each decoded frame. It drives the receiver's input selector, which picks either a local loopback path or the line. It also asks the local transmitter to send one of two reserved training fill frames. When bring-up completes, it raises link-ready.

Two bring-up styles are supported, chosen by a mode pin when the sequence starts.

- **Duplex.** Both ends exchange training frames. This end first sends training frame A until it is in lock and sees training frame A or B from the far end. It then sends training frame B until it receives B back.
- **Unidirectional.** The receiver first listens to the local loopback path to reach frequency lock. It then moves to the line input and waits for phase lock, which is confirmed by a received fill frame.

The time needed to synchronize depends on how closely the two clocks match. For this reason every waiting state is guarded by a timeout. On expiry the timeout restarts the sequence and sets a sticky error flag. Once the link is ready, it stays up only while lock holds and fill or data frames keep arriving. Loss of lock, or a run of invalid frames, drops link-ready and restarts the sequence.

Top module: `lnk_bringup_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `st_code` is 0, and `link_up`, `loop_sel`, `tx_train` and `err_sticky` are all 0.
- R2: In the cycle after leaving state 0 with `mode_uni`=0, the state becomes 3 (train A). There `tx_train` is 2'b01 and `loop_sel` is 0.
- R3: State 3 moves to state 4 (train B, `tx_train`=2'b10) on an edge where `lock_i`=1, `rx_vld`=1 and `rx_kind` is 3 (training A) or 4 (training B). Any other frame kind, or an absent lock, keeps state 3.
- R4: State 4 moves to state 5 (ready) on an edge with `lock_i`=1, `rx_vld`=1 and `rx_kind`=4. In state 5, `link_up`=1 and `tx_train`=2'b00.
- R5: With `mode_uni`=1, state 0 moves to state 1 (frequency acquire), where `loop_sel`=1 and `tx_train`=2'b00. State 1 moves to state 2 (phase acquire, `loop_sel`=0) on an edge with `lock_i`=1.
- R6: State 2 moves to state 5 only on an edge with `lock_i`=1, `rx_vld`=1 and `rx_kind`=1 (fill frame). Other frame kinds keep state 2.
- R7: The waiting states are 1, 2, 3 and 4. If none of them is left by progress within TIMEOUT_CYC cycles, the state returns to 0 after exactly TIMEOUT_CYC cycles in that state, and `err_sticky` becomes 1.
- R8: `err_sticky` stays 1 until `rst_n` goes low. Loss of lock and invalid-frame runs never set it.
- R9: In state 4 or state 5, `lock_i`=0 at an edge returns the state to 0 and clears `link_up`. The sequence then restarts from state 0.
- R10: In state 5, BAD_RUN consecutive valid frames with `rx_kind` in 5..7 (invalid) return the state to 0. Any valid frame of kind 0..4 restarts the count. Cycles with `rx_vld`=0 leave the count unchanged.
- R11: `mode_uni` only matters in state 0. Changing it during a duplex sequence does not alter that sequence.
- R12: `st_code` encodes the state as follows: 0 reset, 1 frequency acquire, 2 phase acquire, 3 train A, 4 train B, 5 ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_uni | input | 1 | 1 selects unidirectional bring-up, 0 duplex |
| lock_i | input | 1 | Clock-recovery lock indication |
| rx_vld | input | 1 | A decoded frame is present this cycle |
| rx_kind | input | 3 | Decoded frame type: 0 data, 1 fill, 2 control, 3 training A, 4 training B, 5-7 invalid |
| loop_sel | output | 1 | 1 selects the local loopback input, 0 the line |
| tx_train | output | 2 | Training request to local transmitter: 00 none, 01 frame A, 10 frame B |
| link_up | output | 1 | Link ready for user data |
| err_sticky | output | 1 | Sticky bring-up timeout flag |
| st_code | output | 3 | Current state code |

## Verification
The bench builds the block with TIMEOUT_CYC=16, BAD_RUN=3 and LOCK_SYNC=0. The short timeout lets the bench count the exact residence in a stalled state and see the restart and sticky error within a few dozen cycles. A run limit of three leaves room to show that an interleaved good frame, or an idle cycle, handles the count correctly. With no lock synchronizer stages, every state change lands one edge after its cause, so each transition is checked at a fixed cycle.

// File: rtl/lnk_bringup_pkg.sv
package lnk_bringup_pkg;

   typedef enum logic [2:0] {
      LS_RESET   = 3'd0,
      LS_FREQ    = 3'd1,
      LS_PHASE   = 3'd2,
      LS_TRAIN_A = 3'd3,
      LS_TRAIN_B = 3'd4,
      LS_READY   = 3'd5
   } lnk_state_e;

   localparam int unsigned KIND_W = 3;

   localparam logic [KIND_W-1:0] FK_DATA  = 3'd0;
   localparam logic [KIND_W-1:0] FK_FILL  = 3'd1;
   localparam logic [KIND_W-1:0] FK_CTRL  = 3'd2;
   localparam logic [KIND_W-1:0] FK_TRN_A = 3'd3;
   localparam logic [KIND_W-1:0] FK_TRN_B = 3'd4;

   localparam logic [1:0] TRQ_NONE = 2'b00;
   localparam logic [1:0] TRQ_A    = 2'b01;
   localparam logic [1:0] TRQ_B    = 2'b10;

   function automatic logic kind_is_bad(input logic [KIND_W-1:0] k);
      return k > FK_TRN_B;
   endfunction

   function automatic logic st_is_waiting(input lnk_state_e s);
      return (s == LS_FREQ) || (s == LS_PHASE) ||
             (s == LS_TRAIN_A) || (s == LS_TRAIN_B);
   endfunction

endpackage

// File: rtl/lnk_wait_timer.sv
module lnk_wait_timer #(
   parameter int unsigned TIMEOUT_CYC = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic expired
);
   localparam int unsigned TW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
   localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_limit
         $error("lnk_wait_timer: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || clr) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = run && (cnt_q == LAST);

   AST_TMO_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R7

endmodule

// File: rtl/lnk_run_monitor.sv
module lnk_run_monitor
   import lnk_bringup_pkg::*;
#(
   parameter int unsigned BAD_RUN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rx_vld,
   input  logic [KIND_W-1:0] rx_kind,
   output logic              trip
);
   localparam int unsigned RW = (BAD_RUN > 1) ? $clog2(BAD_RUN + 1) : 1;
   localparam logic [RW-1:0] LAST = RW'(BAD_RUN - 1);

   generate
      if (BAD_RUN < 1) begin : g_bad_run
         $error("lnk_run_monitor: BAD_RUN must be at least 1");
      end
   endgenerate

   logic [RW-1:0] run_q;
   logic          bad_now;

   assign bad_now = rx_vld && kind_is_bad(rx_kind);
   assign trip    = en && bad_now && (run_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         run_q <= '0;
      end else if (rx_vld) begin
         if (!bad_now || trip) begin
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   AST_RUN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= LAST); // R10

   AST_RUN_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !rx_vld) |=> (!en || $stable(run_q))); // R10

endmodule

// File: rtl/lnk_seq_fsm.sv
module lnk_seq_fsm
   import lnk_bringup_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_uni,
   input  logic              lock,
   input  logic              rx_vld,
   input  logic [KIND_W-1:0] rx_kind,
   input  logic              tmo_exp,
   input  logic              bad_trip,
   output lnk_state_e        st_q,
   output logic              st_chg,
   output logic              err_q
);
   lnk_state_e nxt;
   logic       tmo_fire;

   always_comb begin
      nxt      = st_q;
      tmo_fire = 1'b0;
      unique case (st_q)
         LS_RESET: begin
            nxt = mode_uni ? LS_FREQ : LS_TRAIN_A;
         end
         LS_FREQ: begin
            if (lock) begin
               nxt = LS_PHASE;
            end else if (tmo_exp) begin
               nxt      = LS_RESET;
               tmo_fire = 1'b1;
            end
         end
         LS_PHASE: begin
            if (lock && rx_vld && (rx_kind == FK_FILL)) begin
               nxt = LS_READY;
            end else if (tmo_exp) begin
               nxt      = LS_RESET;
               tmo_fire = 1'b1;
            end
         end
         LS_TRAIN_A: begin
            if (lock && rx_vld && ((rx_kind == FK_TRN_A) || (rx_kind == FK_TRN_B))) begin
               nxt = LS_TRAIN_B;
            end else if (tmo_exp) begin
               nxt      = LS_RESET;
               tmo_fire = 1'b1;
            end
         end
         LS_TRAIN_B: begin
            if (!lock) begin
               nxt = LS_RESET;
            end else if (rx_vld && (rx_kind == FK_TRN_B)) begin
               nxt = LS_READY;
            end else if (tmo_exp) begin
               nxt      = LS_RESET;
               tmo_fire = 1'b1;
            end
         end
         LS_READY: begin
            if (!lock || bad_trip) begin
               nxt = LS_RESET;
            end
         end
         default: nxt = LS_RESET;
      endcase
   end

   assign st_chg = (nxt != st_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= LS_RESET;
         err_q <= 1'b0;
      end else begin
         st_q <= nxt;
         if (tmo_fire) begin
            err_q <= 1'b1;
         end
      end
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q); // R8

   AST_TMO_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_exp && st_is_waiting(st_q) && !st_chg) |-> 1'b0); // R7

   AST_READY_HAD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != LS_READY) ##1 (st_q == LS_READY) |-> $past(lock)); // R9

   AST_READY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != LS_READY) ##1 (st_q == LS_READY)
         |-> ($past(st_q) == LS_TRAIN_B) || ($past(st_q) == LS_PHASE)); // R4

   AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LS_RESET) |=> (st_q != LS_RESET)); // R12

endmodule

// File: rtl/lnk_bringup_ctrl.sv
module lnk_bringup_ctrl
   import lnk_bringup_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYC = 4096,
   parameter int unsigned BAD_RUN     = 8,
   parameter int unsigned LOCK_SYNC   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_uni,
   input  logic       lock_i,
   input  logic       rx_vld,
   input  logic [2:0] rx_kind,
   output logic       loop_sel,
   output logic [1:0] tx_train,
   output logic       link_up,
   output logic       err_sticky,
   output logic [2:0] st_code
);
   generate
      if (LOCK_SYNC > 4) begin : g_bad_sync
         $error("lnk_bringup_ctrl: LOCK_SYNC above 4 is not supported");
      end
   endgenerate

   logic lock_s;

   generate
      if (LOCK_SYNC == 0) begin : g_lock_direct
         assign lock_s = lock_i;
      end else begin : g_lock_sync
         logic [LOCK_SYNC-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q <= {sync_q[LOCK_SYNC-2+((LOCK_SYNC==1)?1:0):0], lock_i};
            end
         end
         assign lock_s = sync_q[LOCK_SYNC-1];
      end
   endgenerate

   lnk_state_e st_q;
   logic       st_chg;
   logic       tmo_exp;
   logic       bad_trip;
   logic       err_q;

   lnk_wait_timer #(
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (st_is_waiting(st_q)),
      .clr     (st_chg),
      .expired (tmo_exp)
   );

   lnk_run_monitor #(
      .BAD_RUN (BAD_RUN)
   ) u_runmon (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (st_q == LS_READY),
      .rx_vld  (rx_vld),
      .rx_kind (rx_kind),
      .trip    (bad_trip)
   );

   lnk_seq_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_uni (mode_uni),
      .lock     (lock_s),
      .rx_vld   (rx_vld),
      .rx_kind  (rx_kind),
      .tmo_exp  (tmo_exp),
      .bad_trip (bad_trip),
      .st_q     (st_q),
      .st_chg   (st_chg),
      .err_q    (err_q)
   );

   always_comb begin
      unique case (st_q)
         LS_TRAIN_A: tx_train = TRQ_A;
         LS_TRAIN_B: tx_train = TRQ_B;
         default:    tx_train = TRQ_NONE;
      endcase
   end

   assign loop_sel   = (st_q == LS_FREQ);
   assign link_up    = (st_q == LS_READY);
   assign err_sticky = err_q;
   assign st_code    = st_q;

   AST_TRAIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_train)); // R2

   AST_LOOP_NO_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      loop_sel |-> (tx_train == TRQ_NONE) && !link_up); // R5

   AST_UP_NO_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      link_up |-> (tx_train == TRQ_NONE)); // R4

   AST_DROP_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_up) |-> (st_code == 3'd0)); // R9

endmodule

// File: tb/tb_lnk_bringup_ctrl.sv
module tb_lnk_bringup_ctrl;

   localparam int TMO = 16;
   localparam int RUN = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_uni = 1'b0;
   logic       lock_i = 1'b0;
   logic       rx_vld = 1'b0;
   logic [2:0] rx_kind = 3'd0;
   logic       loop_sel;
   logic [1:0] tx_train;
   logic       link_up;
   logic       err_sticky;
   logic [2:0] st_code;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   lnk_bringup_ctrl #(
      .TIMEOUT_CYC (TMO),
      .BAD_RUN     (RUN),
      .LOCK_SYNC   (0)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_uni   (mode_uni),
      .lock_i     (lock_i),
      .rx_vld     (rx_vld),
      .rx_kind    (rx_kind),
      .loop_sel   (loop_sel),
      .tx_train   (tx_train),
      .link_up    (link_up),
      .err_sticky (err_sticky),
      .st_code    (st_code)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic feed(input logic l, input logic v, input logic [2:0] k);
      lock_i  = l;
      rx_vld  = v;
      rx_kind = k;
   endtask

   task automatic do_reset(input logic uni);
      rst_n    = 1'b0;
      mode_uni = uni;
      feed(1'b0, 1'b0, 3'd0);
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
   endtask

   task automatic reach_ready_duplex();
      do_reset(1'b0);
      tick();
      feed(1'b1, 1'b1, 3'd3);
      tick();
      feed(1'b1, 1'b1, 3'd4);
      tick();
      feed(1'b1, 1'b1, 3'd1);
   endtask

   task automatic t_reset();
      do_reset(1'b0);
      chk("R1", "state", st_code, 0);
      chk("R1", "link_up", link_up, 0);
      chk("R1", "loop_sel", loop_sel, 0);
      chk("R1", "tx_train", tx_train, 0);
      chk("R1", "err", err_sticky, 0);
   endtask

   task automatic t_duplex();
      do_reset(1'b0);
      tick();
      chk("R2", "state", st_code, 3);
      chk("R2", "tx_train", tx_train, 1);
      chk("R2", "loop_sel", loop_sel, 0);
      feed(1'b0, 1'b1, 3'd3);
      tick();
      chk("R3", "no lock holds", st_code, 3);
      feed(1'b1, 1'b1, 3'd1);
      tick();
      chk("R3", "fill holds", st_code, 3);
      feed(1'b1, 1'b0, 3'd3);
      tick();
      chk("R3", "no valid holds", st_code, 3);
      feed(1'b1, 1'b1, 3'd3);
      tick();
      chk("R3", "state", st_code, 4);
      chk("R3", "tx_train", tx_train, 2);
      tick();
      chk("R4", "A in B holds", st_code, 4);
      feed(1'b1, 1'b1, 3'd4);
      tick();
      chk("R4", "state", st_code, 5);
      chk("R4", "link_up", link_up, 1);
      chk("R4", "tx_train", tx_train, 0);
      chk("R8", "err", err_sticky, 0);
   endtask

   task automatic t_b_in_a();
      do_reset(1'b0);
      tick();
      feed(1'b1, 1'b1, 3'd4);
      tick();
      chk("R3", "B advances A", st_code, 4);
   endtask

   task automatic t_uni();
      do_reset(1'b1);
      tick();
      chk("R5", "state", st_code, 1);
      chk("R5", "loop_sel", loop_sel, 1);
      chk("R5", "tx_train", tx_train, 0);
      feed(1'b0, 1'b1, 3'd1);
      tick();
      chk("R5", "no lock holds", st_code, 1);
      feed(1'b1, 1'b0, 3'd0);
      tick();
      chk("R5", "phase state", st_code, 2);
      chk("R5", "loop_sel", loop_sel, 0);
      feed(1'b1, 1'b1, 3'd3);
      tick();
      chk("R6", "train holds", st_code, 2);
      feed(1'b1, 1'b1, 3'd0);
      tick();
      chk("R6", "data holds", st_code, 2);
      feed(1'b1, 1'b1, 3'd1);
      tick();
      chk("R6", "state", st_code, 5);
      chk("R6", "link_up", link_up, 1);
   endtask

   task automatic t_timeout();
      int n;
      do_reset(1'b0);
      tick();
      n = 1;
      for (int i = 0; i < 3 * TMO; i++) begin
         tick();
         if (st_code == 3'd3) n++;
         else break;
      end
      chk("R7", "cycles in wait", n, TMO);
      chk("R7", "state after", st_code, 0);
      chk("R7", "err", err_sticky, 1);
      tick();
      chk("R8", "restart", st_code, 3);
      chk("R8", "err held", err_sticky, 1);
      do_reset(1'b0);
      chk("R8", "err cleared", err_sticky, 0);
   endtask

   task automatic t_lockloss();
      reach_ready_duplex();
      chk("R9", "ready", st_code, 5);
      feed(1'b0, 1'b0, 3'd0);
      tick();
      chk("R9", "state", st_code, 0);
      chk("R9", "link_up", link_up, 0);
      chk("R8", "err", err_sticky, 0);
      tick();
      chk("R9", "restart", st_code, 3);
      feed(1'b1, 1'b1, 3'd3);
      tick();
      chk("R9", "in B", st_code, 4);
      feed(1'b0, 1'b0, 3'd0);
      tick();
      chk("R9", "B lock loss", st_code, 0);
   endtask

   task automatic t_badrun();
      reach_ready_duplex();
      feed(1'b1, 1'b1, 3'd7);
      tick();
      feed(1'b1, 1'b1, 3'd6);
      tick();
      chk("R10", "two bad", st_code, 5);
      feed(1'b1, 1'b1, 3'd1);
      tick();
      feed(1'b1, 1'b1, 3'd5);
      tick();
      feed(1'b1, 1'b0, 3'd0);
      tick();
      feed(1'b1, 1'b1, 3'd7);
      tick();
      chk("R10", "good clears", st_code, 5);
      chk("R10", "link_up", link_up, 1);
      feed(1'b1, 1'b1, 3'd7);
      tick();
      chk("R10", "trip", st_code, 0);
      chk("R10", "link_up", link_up, 0);
      chk("R8", "err", err_sticky, 0);
   endtask

   task automatic t_mode_hold();
      do_reset(1'b0);
      tick();
      mode_uni = 1'b1;
      feed(1'b1, 1'b1, 3'd3);
      tick();
      chk("R11", "still duplex", st_code, 4);
      chk("R11", "loop_sel", loop_sel, 0);
      feed(1'b1, 1'b1, 3'd4);
      tick();
      chk("R11", "ready", st_code, 5);
      feed(1'b0, 1'b0, 3'd0);
      tick();
      tick();
      chk("R12", "uni after restart", st_code, 1);
   endtask

   initial begin
      t_reset();
      t_duplex();
      t_b_in_a();
      t_uni();
      t_timeout();
      t_lockloss();
      t_badrun();
      t_mode_hold();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule